// File: doc/BRIEF.md
# Single-Port RAM Access Arbiter with Posted Write

This block places a single-port synchronous RAM behind two independent requesters, a reader and a writer. Each requester uses a valid/ready handshake. The array completes exactly one operation per clock: a read, a write, or nothing. When both requesters ask in the same cycle, the block resolves the clash with a priority policy fixed by a parameter, so both can run at once without corrupting the array.

An optional one-entry posted-write slot can be enabled by a parameter. With the slot, a write is accepted even while the array is serving a read. The parked write is committed on the next cycle in which the array is free. A read that targets the parked address gets the parked data straight from the slot. Read data is registered and arrives one cycle after the read handshake, marked by a single-cycle valid pulse.

The array's select and write-strobe lines are brought out as observation ports. Integration checks can count array cycles without reaching into the hierarchy.

Top module: `spram_arb_wrap`

## Requirements
- R1: The array lines use these encodings: a read cycle drives `ram_sel_n`=0 and `ram_wr_n`=1, and a write cycle drives `ram_sel_n`=0 and `ram_wr_n`=0. A cycle never carries both a read and a write.
- R2: `ram_sel_n` is 1 in any cycle with no read request, no write request and no parked write.
- R3: `rd_data_valid` is 1 in exactly the cycle after each read handshake (`rd_valid` and `rd_ready` both 1 at a clock edge), and `rd_data` holds the result in that cycle.
- R4: With `PRIO` = `PRIO_READ`, a read request always gets `rd_ready`=1. Without the slot, a write that arrives together with a read gets `wr_ready`=0 in that cycle.
- R5: With `PRIO` = `PRIO_WRITE` and the slot enabled, a parked write is committed before any read. In that cycle both `rd_ready` and `wr_ready` are 0, so writes stay in order.
- R6: With the slot enabled, a write accepted while the array is busy is parked and then committed on the first cycle with no competing array read.
- R7: While the slot is occupied and cannot drain in the current cycle, `wr_ready` is 0 and the request stays stalled.
- R8: A read of the address held in the slot returns the parked data. Under `PRIO_READ`, the slot drains in that same cycle.
- R9: Every read returns the data of the most recent write accepted in an earlier cycle to the same address. A write accepted in the same cycle as the read is not visible to it.
- R10: While `rst_n` is 0, `rd_ready`, `wr_ready` and `rd_data_valid` are 0. Reset also empties the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request, held until accepted |
| rd_addr | input | ADDR_W | Read address |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_data | output | DATA_W | Read result, valid with rd_data_valid |
| rd_data_valid | output | 1 | One-cycle pulse after a read handshake |
| wr_valid | input | 1 | Write request, held until accepted |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Write request accepted this cycle |
| ram_sel_n | output | 1 | Array select, low on any array cycle |
| ram_wr_n | output | 1 | Array write strobe, low on a write cycle |

## Verification
The bench exercises three configurations: read priority with the slot, write priority with the slot, and read priority without it. It drives random overlapping traffic to a small address range so that reads often hit a parked write. A design without forwarding would return stale array contents on those reads. A design that let a second write overwrite an occupied slot would lose a write, and the scoreboard would then see a stale value. Directed sequences cover several further faults: a write-priority design that served a read before draining the slot, a design that left the slot undrained during an idle cycle, and a design that counted a same-cycle write as visible to the read.

// File: rtl/spram_arb_pkg.sv
package spram_arb_pkg;
   typedef enum logic {
      PRIO_READ  = 1'b0,
      PRIO_WRITE = 1'b1
   } prio_e;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } arr_op_e;
endpackage

// File: rtl/spram_model.sv
module spram_model #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!sel_n) begin
         if (!wr_n) cells[addr] <= wdata;
         else       q <= cells[addr];
      end
   end
endmodule

// File: rtl/spram_arb_ctrl.sv
module spram_arb_ctrl
   import spram_arb_pkg::*;
#(
   parameter int    ADDR_W   = 8,
   parameter int    DATA_W   = 32,
   parameter prio_e PRIO     = PRIO_READ,
   parameter bit    USE_WBUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_ready,
   output logic              wr_ready,
   output arr_op_e           op,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              fwd_hit,
   output logic [DATA_W-1:0] fwd_data,
   output logic              pend
);
   logic              rd_rdy_i, wr_rdy_i;
   logic              rd_go, wr_go;
   logic              bv;
   logic [ADDR_W-1:0] baddr;
   logic [DATA_W-1:0] bdata;
   logic              hit, drain;

   assign rd_ready = rst_n & rd_rdy_i;
   assign wr_ready = rst_n & wr_rdy_i;
   assign rd_go    = rd_valid & rd_ready;
   assign wr_go    = wr_valid & wr_ready;
   assign pend     = bv;
   assign fwd_data = bdata;

   generate
      if (USE_WBUF) begin : g_slot
         assign hit = bv && (baddr == rd_addr);

         if (PRIO == PRIO_READ) begin : g_rf
            assign rd_rdy_i = 1'b1;
            assign drain    = bv && (!rd_valid || hit);
            assign wr_rdy_i = !bv || drain;

            // R6
            drain_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (bv && !rd_valid && !wr_go) |=> !bv);
         end else begin : g_wf
            assign rd_rdy_i = !bv;
            assign drain    = bv;
            assign wr_rdy_i = !bv;

            // R5
            drain_wf_chk: assert property (@(posedge clk) disable iff (!rst_n)
               bv |=> !bv);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bv <= 1'b0;
            else        bv <= wr_go | (bv & !drain);
         end

         always_ff @(posedge clk) begin
            if (wr_go) begin
               baddr <= wr_addr;
               bdata <= wr_data;
            end
         end

         always_comb begin
            op        = OP_IDLE;
            arr_addr  = rd_addr;
            arr_wdata = bdata;
            if (rd_go && !hit) begin
               op = OP_READ;
            end else if (drain) begin
               op       = OP_WRITE;
               arr_addr = baddr;
            end
         end

         assign fwd_hit = rd_go && hit;
      end else begin : g_direct
         assign bv      = 1'b0;
         assign baddr   = '0;
         assign bdata   = '0;
         assign hit     = 1'b0;
         assign drain   = 1'b0;
         assign fwd_hit = 1'b0;

         if (PRIO == PRIO_READ) begin : g_rf
            assign rd_rdy_i = 1'b1;
            assign wr_rdy_i = !rd_valid;
         end else begin : g_wf
            assign wr_rdy_i = 1'b1;
            assign rd_rdy_i = !wr_valid;
         end

         always_comb begin
            op        = OP_IDLE;
            arr_addr  = rd_addr;
            arr_wdata = wr_data;
            if (rd_go) begin
               op = OP_READ;
            end else if (wr_go) begin
               op       = OP_WRITE;
               arr_addr = wr_addr;
            end
         end

         // R1
         excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_go && wr_go));
      end
   endgenerate
endmodule

// File: rtl/spram_arb_rdpath.sv
module spram_arb_rdpath #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              fwd_hit,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic [DATA_W-1:0] ram_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_valid
);
   logic              dv_q, use_fwd_q;
   logic [DATA_W-1:0] fwd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q      <= 1'b0;
         use_fwd_q <= 1'b0;
      end else begin
         dv_q      <= rd_go;
         use_fwd_q <= fwd_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (fwd_hit) fwd_q <= fwd_data;
   end

   assign rd_data       = use_fwd_q ? fwd_q : ram_q;
   assign rd_data_valid = dv_q;

   // R8
   fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_hit |=> (rd_data == $past(fwd_data)));
endmodule

// File: rtl/spram_arb_wrap.sv
module spram_arb_wrap
   import spram_arb_pkg::*;
#(
   parameter int    ADDR_W   = 8,
   parameter int    DATA_W   = 32,
   parameter prio_e PRIO     = PRIO_READ,
   parameter bit    USE_WBUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_valid,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              ram_sel_n,
   output logic              ram_wr_n
);
   generate
      if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
         $error("spram_arb_wrap: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("spram_arb_wrap: DATA_W must be positive");
      end
   endgenerate

   arr_op_e           op;
   logic [ADDR_W-1:0] arr_addr;
   logic [DATA_W-1:0] arr_wdata, ram_q, fwd_data;
   logic              fwd_hit, pend, rd_go;

   spram_arb_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO(PRIO), .USE_WBUF(USE_WBUF)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(rd_valid), .rd_addr(rd_addr),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_ready(rd_ready), .wr_ready(wr_ready),
      .op(op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .fwd_hit(fwd_hit), .fwd_data(fwd_data), .pend(pend)
   );

   assign ram_sel_n = (op == OP_IDLE);
   assign ram_wr_n  = (op != OP_WRITE);
   assign rd_go     = rd_valid & rd_ready;

   spram_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
      .clk(clk), .sel_n(ram_sel_n), .wr_n(ram_wr_n),
      .addr(arr_addr), .wdata(arr_wdata), .q(ram_q)
   );

   spram_arb_rdpath #(.DATA_W(DATA_W)) i_rdpath (
      .clk(clk), .rst_n(rst_n), .rd_go(rd_go),
      .fwd_hit(fwd_hit), .fwd_data(fwd_data), .ram_q(ram_q),
      .rd_data(rd_data), .rd_data_valid(rd_data_valid)
   );

   // R3
   rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> rd_data_valid);
   // R3
   rdv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> !rd_data_valid);
   // R2
   idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && !wr_valid && !pend) |-> ram_sel_n);

   // R10
   always_comb begin
      if (rst_n === 1'b0) begin
         reset_ready_chk: assert (!rd_ready && !wr_ready);
      end
   end
endmodule

// File: tb/test_spram_arb_wrap.sv
module test_spram_arb_wrap;
   import spram_arb_pkg::*;

   localparam int CLK_P  = 10;
   localparam int Q      = CLK_P / 4;
   localparam int AW     = 4;
   localparam int DW     = 8;
   localparam int NRAND  = 2500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   logic [2:0] done = '0;

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   end

   initial begin
      wait (&done);
      repeat (3) @(negedge clk);
      summary();
   end

   initial begin
      #(CLK_P * 200000);
      chk(1'b0, "WATCHDOG", 0, 1);
      summary();
   end

   for (genvar g = 0; g < 3; g++) begin : g_cfg
      localparam prio_e P  = (g == 1) ? PRIO_WRITE : PRIO_READ;
      localparam bit    WB = (g != 2);

      logic          rv = 1'b0, wv = 1'b0;
      logic [AW-1:0] ra = '0, wa = '0;
      logic [DW-1:0] wd = '0;
      logic          rd_ready, wr_ready, dv, sel_n, wr_n;
      logic [DW-1:0] rd_data;

      int  ref_mem [1 << AW];
      bit  known   [1 << AW];
      int  exp_q [$];
      bit  prev_fire = 1'b0;

      spram_arb_wrap #(
         .ADDR_W(AW), .DATA_W(DW), .PRIO(P), .USE_WBUF(WB)
      ) i_spram_arb_wrap (
         .clk(clk), .rst_n(rst_n),
         .rd_valid(rv), .rd_addr(ra), .rd_ready(rd_ready),
         .rd_data(rd_data), .rd_data_valid(dv),
         .wr_valid(wv), .wr_addr(wa), .wr_data(wd), .wr_ready(wr_ready),
         .ram_sel_n(sel_n), .ram_wr_n(wr_n)
      );

      // scoreboard monitor: compares results, then records new handshakes
      initial begin
         forever begin
            @(negedge clk);
            #(Q);
            if (rst_n) begin
               chk(dv == prev_fire, "R3 valid pulse", int'(dv), int'(prev_fire));
               if (dv && exp_q.size() > 0) begin
                  int e;
                  e = exp_q.pop_front();
                  if (e >= 0) chk(rd_data == DW'(e), "R9 read data", int'(rd_data), e);
               end
               prev_fire = rv && rd_ready;
               if (rv && rd_ready) exp_q.push_back(known[ra] ? ref_mem[ra] : -1);
               if (wv && wr_ready) begin
                  ref_mem[wa] = int'(wd);
                  known[wa]   = 1'b1;
               end
            end
         end
      end

      task automatic cyc(input bit r, input logic [AW-1:0] a_r,
                         input bit w, input logic [AW-1:0] a_w, input logic [DW-1:0] d);
         @(negedge clk);
         rv = r; ra = a_r; wv = w; wa = a_w; wd = d;
         #(Q);
      endtask

      initial begin
         bit rfired, wfired;
         rv = 1'b1; wv = 1'b1;
         @(negedge clk);
         #(Q);
         // R10 readies and valid held low in reset
         chk(!rd_ready && !wr_ready && !dv, "R10 reset outputs",
             int'({rd_ready, wr_ready, dv}), 0);
         rv = 1'b0; wv = 1'b0;
         wait (rst_n === 1'b1);
         cyc(0, 0, 0, 0, 0);
         chk(sel_n == 1'b1, "R2 idle select", int'(sel_n), 1);

         if (g == 0) begin
            cyc(0, 0, 1, 0, 8'h11);
            chk(wr_ready == 1'b1, "R6 slot accepts", int'(wr_ready), 1);
            cyc(1, 0, 1, 1, 8'h22);
            chk(!sel_n && !wr_n, "R8 drain during hit", int'({sel_n, wr_n}), 0);
            chk(rd_ready && wr_ready, "R4 both ready", int'({rd_ready, wr_ready}), 3);
            cyc(1, 2, 1, 3, 8'h33);
            chk(dv && rd_data == 8'h11, "R8 forwarded data", int'(rd_data), 'h11);
            chk(!sel_n && wr_n, "R1 read encoding", int'({sel_n, wr_n}), 1);
            chk(wr_ready == 1'b0, "R7 stall when slot full", int'(wr_ready), 0);
            cyc(0, 0, 1, 3, 8'h33);
            chk(!sel_n && !wr_n && wr_ready, "R6 drain on free cycle",
                int'({sel_n, wr_n, wr_ready}), 1);
            cyc(0, 0, 0, 0, 0);
            chk(!sel_n && !wr_n, "R6 second drain", int'({sel_n, wr_n}), 0);
            cyc(0, 0, 0, 0, 0);
            chk(sel_n == 1'b1, "R2 idle after drain", int'(sel_n), 1);
         end else if (g == 1) begin
            cyc(1, 0, 1, 0, 8'h44);
            chk(rd_ready && wr_ready, "R5 both accepted when slot empty",
                int'({rd_ready, wr_ready}), 3);
            cyc(1, 0, 1, 1, 8'h55);
            chk(!rd_ready && !wr_ready, "R5 slot drains first",
                int'({rd_ready, wr_ready}), 0);
            chk(!sel_n && !wr_n, "R1 write encoding", int'({sel_n, wr_n}), 0);
            cyc(1, 0, 1, 1, 8'h55);
            chk(rd_ready && wr_ready, "R5 accepted after drain",
                int'({rd_ready, wr_ready}), 3);
            cyc(0, 0, 0, 0, 0);
            chk(dv && rd_data == 8'h44, "R5 read after drained write", int'(rd_data), 'h44);
            chk(!sel_n && !wr_n, "R6 drain when idle", int'({sel_n, wr_n}), 0);
            cyc(0, 0, 0, 0, 0);
            chk(sel_n == 1'b1, "R2 idle", int'(sel_n), 1);
         end else begin
            cyc(1, 0, 1, 0, 8'h66);
            chk(rd_ready && !wr_ready, "R4 read wins", int'({rd_ready, wr_ready}), 2);
            chk(!sel_n && wr_n, "R1 read encoding", int'({sel_n, wr_n}), 1);
            cyc(0, 0, 1, 0, 8'h66);
            chk(wr_ready && !sel_n && !wr_n, "R1 direct write",
                int'({wr_ready, sel_n, wr_n}), 4);
            cyc(1, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
            chk(dv && rd_data == 8'h66, "R9 read after write", int'(rd_data), 'h66);
            chk(sel_n == 1'b1, "R2 idle", int'(sel_n), 1);
         end

         rfired = 1'b0;
         wfired = 1'b0;
         for (int i = 0; i < NRAND; i++) begin
            @(negedge clk);
            if (!rv || rfired) begin
               rv = ($urandom % 10) < 6;
               ra = AW'($urandom % 4);
            end
            if (!wv || wfired) begin
               wv = ($urandom % 10) < 3;
               wa = AW'($urandom % 4);
               wd = DW'($urandom);
            end
            #(Q);
            rfired = rv && rd_ready;
            wfired = wv && wr_ready;
         end
         @(negedge clk);
         if (rfired) rv = 1'b0;
         if (wfired) wv = 1'b0;
         while (rv || wv) begin
            #(Q);
            rfired = rv && rd_ready;
            wfired = wv && wr_ready;
            @(negedge clk);
            if (rfired) rv = 1'b0;
            if (wfired) wv = 1'b0;
         end
         repeat (4) @(negedge clk);
         done[g] = 1'b1;
      end
   end
endmodule